// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by looking up one entry in a flat page table held in memory. The low `PG_SHIFT` bits of the virtual address are the page offset and pass through unchanged. The remaining upper bits form the virtual page number, which selects one entry in the table. The table begins at the byte address held in a table base register.

For each accepted request the block issues exactly one memory read for the entry. It checks the entry's present, write and user bits against the request, and then returns one response. The response carries either the physical address, which is the frame number joined to the offset, or a fault code.

Software loads the base register through a write strobe. A write is honoured only while the block is idle, and the new value is used from the next request onward. Parameters set the virtual width, the physical width and the page-size exponent. The entry word width and the entry stride are derived from these parameters.

Top module: `page_xlate`

## Requirements
- R1: The low PG_SHIFT bits of a successful response's physical address equal the low PG_SHIFT bits of the request's virtual address, including an offset of all ones.
- R2: A successful response's physical address equals frame × 2^PG_SHIFT + offset. With 8-bit virtual addresses, 10-bit physical addresses, 64-byte pages and frames [2,5,1,8] for pages 0 to 3, virtual address 241 gives 561.
- R3: Each accepted request produces exactly one single-cycle entry read, at byte address base + page_number × entry_bytes. With the defaults the entry is 1 byte wide.
- R4: An entry word holds the present bit at bit 0, the write-allowed bit at bit 1 and the user-allowed bit at bit 2. The frame number occupies the bits above bit 2.
- R5: An entry whose present bit is 0 yields fault code 1 and physical address 0, whatever the request's write and user flags are.
- R6: A write request to a present page whose write bit is 0 yields fault code 2. A read of that page succeeds.
- R7: A user-mode request to a present page whose user bit is 0 yields fault code 3. A supervisor request to that page succeeds. When both the write check and the user check fail, code 2 is reported.
- R8: The busy output rises in the cycle after a request is accepted. It stays high until the cycle in which the response is valid, when it reads 0. A request raised while busy is high is ignored and produces no read and no response.
- R9: A base write made while busy is high is discarded. A base write made while idle applies from the next request.
- R10: After reset, busy, rsp_valid and mem_rd_valid are 0 and the base register is 0. A fault-free response carries code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | PA_W | New table base byte address |
| req_valid | input | 1 | Translation request, accepted when busy is 0 |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| busy | output | 1 | Translation in progress |
| mem_rd_valid | output | 1 | Entry read strobe, one cycle |
| mem_rd_addr | output | PA_W | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | PTE_W | Entry word |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_pa | output | PA_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 write denied, 3 user denied |

## Verification
The hardest case to reach from the ports is the window while a translation is in flight. Both a stray request and a base write can arrive in that window, and neither may disturb the read already in progress. The bench makes the memory model answer after several cycles to widen this window. While busy is high it pulses a second request and a base write. It then checks that only one read was issued and that the response belongs to the first request. The next request must still use the old base. Fault priority is covered by entries that fail more than one check at once.

// File: rtl/pgx_pkg.sv
// Shared types for the page table translator.
package pgx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_WRITE  = 2'd2,
        FLT_USER   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_e;
endpackage

// File: rtl/pgx_entry_addr.sv
// Computes the byte address of a page table entry from the table base and
// the virtual page number. Assumes the entry stride is a power of two.
module pgx_entry_addr #(
    parameter int VA_W      = 8,
    parameter int PA_W      = 10,
    parameter int PG_SHIFT  = 6,
    parameter int ENT_SHIFT = 0
) (
    input  logic [PA_W-1:0] base,
    input  logic [VA_W-1:0] va,
    output logic [PA_W-1:0] addr
);
    localparam int VPN_W = VA_W - PG_SHIFT;

    logic [VPN_W-1:0] vpn;
    logic [PA_W-1:0]  vpn_ext;

    // Scale the page number by the entry stride and add the base.
    always_comb begin
        vpn     = va[VA_W-1:PG_SHIFT];
        vpn_ext = PA_W'(vpn);
        addr    = base + (vpn_ext << ENT_SHIFT);
    end
endmodule

// File: rtl/pgx_prot_check.sv
// Applies the present, write and user checks to a fetched entry and forms
// the physical address. Assumes the entry layout {frame, u, w, p}.
// Priority order: absent, then write denied, then user denied.
module pgx_prot_check
    import pgx_pkg::*;
#(
    parameter int PA_W     = 10,
    parameter int PG_SHIFT = 6,
    parameter int PTE_W    = PA_W - PG_SHIFT + 3
) (
    input  logic [PTE_W-1:0]    pte,
    input  logic [PG_SHIFT-1:0] offset,
    input  logic                is_write,
    input  logic                is_user,
    output logic [PA_W-1:0]     pa,
    output fault_e              fault
);
    localparam int PPN_W = PA_W - PG_SHIFT;

    logic             bit_p;
    logic             bit_w;
    logic             bit_u;
    logic [PPN_W-1:0] frame;

    // Decode the entry and pick the highest-priority fault.
    always_comb begin
        bit_p = pte[0];
        bit_w = pte[1];
        bit_u = pte[2];
        frame = pte[PTE_W-1:3];
        if (!bit_p)                fault = FLT_ABSENT;
        else if (is_write && !bit_w) fault = FLT_WRITE;
        else if (is_user && !bit_u)  fault = FLT_USER;
        else                         fault = FLT_NONE;
        pa = (fault == FLT_NONE) ? {frame, offset} : '0;
    end
endmodule

// File: rtl/pgx_seq.sv
// Sequencer: idle -> issue one entry read -> wait for the entry -> idle.
// Assumes the memory answers only after the issue cycle.
module pgx_seq
    import pgx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic mem_rsp_valid,
    output logic busy,
    output logic issue,
    output logic capture
);
    seq_e state_q;
    seq_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (go) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decoded controls.
    always_comb begin
        busy    = (state_q != ST_IDLE);
        issue   = (state_q == ST_ISSUE);
        capture = (state_q == ST_WAIT) && mem_rsp_valid;
    end

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue); // R3
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> issue); // R8
endmodule

// File: rtl/page_xlate.sv
// Single-level page table translator. One request at a time: it latches the
// request, reads one entry at base + vpn * entry_bytes, checks the permission
// bits and returns the physical address or a fault code for one cycle.
// Assumes the memory returns exactly one data beat per read.
module page_xlate
    import pgx_pkg::*;
#(
    parameter int  VA_W      = 8,
    parameter int  PA_W      = 10,
    parameter int  PG_SHIFT  = 6,
    localparam int PTE_W     = PA_W - PG_SHIFT + 3,
    localparam int ENT_BYTES = (PTE_W + 7) / 8,
    localparam int ENT_SHIFT = $clog2(ENT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [PA_W-1:0]  base_wdata,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             req_user,
    output logic             busy,
    output logic             mem_rd_valid,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault
);
    logic [PA_W-1:0] base_q;
    logic [VA_W-1:0] va_q;
    logic            write_q;
    logic            user_q;
    logic            accept;
    logic            issue;
    logic            capture;
    logic [PA_W-1:0] chk_pa;
    fault_e          chk_fault;
    logic            rsp_valid_q;
    logic [PA_W-1:0] rsp_pa_q;
    fault_e          rsp_fault_q;

    assign accept = req_valid && !busy;

    // Base register: writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 base_q <= '0;
        else if (base_we && !busy)  base_q <= base_wdata;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            write_q <= 1'b0;
            user_q  <= 1'b0;
        end else if (accept) begin
            va_q    <= req_va;
            write_q <= req_write;
            user_q  <= req_user;
        end
    end

    pgx_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (accept),
        .mem_rsp_valid (mem_rsp_valid),
        .busy          (busy),
        .issue         (issue),
        .capture       (capture)
    );

    pgx_entry_addr #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .PG_SHIFT  (PG_SHIFT),
        .ENT_SHIFT (ENT_SHIFT)
    ) u_addr (
        .base (base_q),
        .va   (va_q),
        .addr (mem_rd_addr)
    );

    assign mem_rd_valid = issue;

    pgx_prot_check #(
        .PA_W     (PA_W),
        .PG_SHIFT (PG_SHIFT),
        .PTE_W    (PTE_W)
    ) u_chk (
        .pte      (mem_rsp_data),
        .offset   (va_q[PG_SHIFT-1:0]),
        .is_write (write_q),
        .is_user  (user_q),
        .pa       (chk_pa),
        .fault    (chk_fault)
    );

    // Response register: one-cycle pulse when the entry arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_pa_q    <= '0;
            rsp_fault_q <= FLT_NONE;
        end else begin
            rsp_valid_q <= capture;
            if (capture) begin
                rsp_pa_q    <= chk_pa;
                rsp_fault_q <= chk_fault;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_pa    = rsp_pa_q;
    assign rsp_fault = rsp_fault_q;

    AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q)); // R9
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy); // R8
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0)); // R5
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_pa[PG_SHIFT-1:0] == va_q[PG_SHIFT-1:0])); // R1
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/page_xlate_tb_top.sv
`timescale 1ns/1ps
module page_xlate_tb_top;
    localparam int VA_W = 8;
    localparam int PA_W = 10;
    localparam int PG_SHIFT = 6;
    localparam int PTE_W = PA_W - PG_SHIFT + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             base_we = 1'b0;
    logic [PA_W-1:0]  base_wdata = '0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_va = '0;
    logic             req_write = 1'b0;
    logic             req_user = 1'b0;
    logic             busy;
    logic             mem_rd_valid;
    logic [PA_W-1:0]  mem_rd_addr;
    logic             mem_rsp_valid = 1'b0;
    logic [PTE_W-1:0] mem_rsp_data = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_pa;
    logic [1:0]       rsp_fault;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int rd_count = 0;
    logic [PA_W-1:0]  last_addr = '0;
    logic [PTE_W-1:0] mem [1024];
    logic [PA_W-1:0]  got_pa;
    logic [1:0]       got_fault;
    int               got_rd;

    always #4 clk = ~clk;

    page_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
        .req_user(req_user), .busy(busy), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [PTE_W-1:0] ent(input int frame, input bit u, input bit w, input bit p);
        return {4'(frame), u, w, p};
    endfunction

    // Memory model: answers each read after lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                rd_count++;
                last_addr = mem_rd_addr;
                repeat (lat) @(negedge clk);
                mem_rsp_data  = mem[last_addr];
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic write_base(input logic [PA_W-1:0] b);
        @(negedge clk);
        base_we = 1'b1; base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    // One translation; records result, read count, busy behaviour.
    task automatic xlate(input logic [VA_W-1:0] va, input bit wr, input bit usr, input string tag);
        int start_rd;
        int guard;
        start_rd = rd_count;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {tag, " R8 busy after accept"}, int'(busy), 1);
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid == 1'b1, {tag, " R8 response seen"}, int'(rsp_valid), 1);
        chk(busy == 1'b0, {tag, " R8 idle with response"}, int'(busy), 0);
        got_pa = rsp_pa; got_fault = rsp_fault;
        @(negedge clk);
        got_rd = rd_count - start_rd;
        chk(got_rd == 1, {tag, " R3 one read"}, got_rd, 1);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R10 busy reset", int'(busy), 0);
        chk(rsp_valid == 1'b0, "R10 rsp_valid reset", int'(rsp_valid), 0);
        chk(mem_rd_valid == 1'b0, "R10 mem_rd_valid reset", int'(mem_rd_valid), 0);
        xlate(8'd241, 1'b0, 1'b0, "R10 base");
        chk(last_addr == 10'h003, "R10 base zero addr", int'(last_addr), 3);
        chk(got_fault == 2'd1, "R5 empty entry absent", int'(got_fault), 1);
    endtask

    task automatic t_example();
        write_base(10'h100);
        xlate(8'd241, 1'b0, 1'b0, "R2 example");
        chk(got_pa == 10'd561, "R2 pa 241", int'(got_pa), 561);
        chk(got_fault == 2'd0, "R10 no fault code", int'(got_fault), 0);
        chk(last_addr == 10'h103, "R3 entry addr", int'(last_addr), 259);
    endtask

    task automatic t_offsets();
        xlate(8'h05, 1'b1, 1'b1, "R4 full perms");
        chk(got_pa == 10'd133 && got_fault == 2'd0, "R4 vpn0 write user", int'(got_pa), 133);
        xlate(8'h7F, 1'b0, 1'b1, "R1 max offset");
        chk(got_pa == 10'd383, "R1 offset all ones", int'(got_pa), 383);
        chk(last_addr == 10'h101, "R3 vpn1 addr", int'(last_addr), 257);
        xlate(8'h40, 1'b0, 1'b0, "R1 zero offset");
        chk(got_pa == 10'd320, "R1 offset zero", int'(got_pa), 320);
    endtask

    task automatic t_faults();
        xlate(8'h41, 1'b1, 1'b0, "R6 write denied");
        chk(got_fault == 2'd2, "R6 fault code", int'(got_fault), 2);
        chk(got_pa == 10'd0, "R6 pa zero", int'(got_pa), 0);
        xlate(8'hC1, 1'b0, 1'b1, "R7 user denied");
        chk(got_fault == 2'd3, "R7 fault code", int'(got_fault), 3);
        xlate(8'hC2, 1'b1, 1'b0, "R7 supervisor ok");
        chk(got_fault == 2'd0 && got_pa == 10'd514, "R7 supervisor write", int'(got_pa), 514);
        xlate(8'h81, 1'b0, 1'b0, "R5 absent");
        chk(got_fault == 2'd1 && got_pa == 10'd0, "R5 absent read", int'(got_fault), 1);
        xlate(8'h82, 1'b1, 1'b1, "R5 absent priority");
        chk(got_fault == 2'd1, "R5 absent over write/user", int'(got_fault), 1);
    endtask

    task automatic t_busy();
        int start_rd;
        int resp_cnt;
        lat = 4;
        start_rd = rd_count;
        resp_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = 8'h07; req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_va = 8'hC9;
        base_we = 1'b1; base_wdata = 10'h200;
        @(negedge clk);
        req_valid = 1'b0; base_we = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid) begin
                resp_cnt++;
                got_pa = rsp_pa;
            end
            @(negedge clk);
        end
        chk(resp_cnt == 1, "R8 single response", resp_cnt, 1);
        chk(rd_count - start_rd == 1, "R8 ignored request no read", rd_count - start_rd, 1);
        chk(got_pa == 10'd135, "R8 response of first request", int'(got_pa), 135);
        lat = 1;
        xlate(8'h02, 1'b0, 1'b0, "R9 busy write dropped");
        chk(last_addr == 10'h100, "R9 old base kept", int'(last_addr), 256);
        write_base(10'h200);
        xlate(8'h11, 1'b0, 1'b0, "R9 new base");
        chk(last_addr == 10'h200, "R9 new base addr", int'(last_addr), 512);
        chk(got_pa == 10'd977, "R9 new table frame", int'(got_pa), 977);
        xlate(8'h41, 1'b1, 1'b1, "R7 priority");
        chk(got_fault == 2'd2, "R7 write over user", int'(got_fault), 2);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[10'h100] = ent(2, 1, 1, 1);
        mem[10'h101] = ent(5, 1, 0, 1);
        mem[10'h102] = ent(1, 1, 1, 0);
        mem[10'h103] = ent(8, 0, 1, 1);
        mem[10'h200] = ent(15, 1, 1, 1);
        mem[10'h201] = ent(9, 0, 0, 1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_offsets();
        t_faults();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule